// File: doc/BRIEF.md
# Page-Buffered Write Commit Engine

This block sits behind a serial-bus front-end of a small non-volatile store and turns a write transaction into one timed commit. The front-end opens a transaction with a word address, then passes data bytes one at a time and finally signals the end of the transaction. Each byte goes into an eight-entry page buffer at the current offset. Only the low offset bits advance, and they wrap inside the page. Bytes beyond the page size therefore overwrite earlier ones, and the page part of the address never changes during a transaction.

The memory array is left untouched until the end-of-transaction pulse arrives. At that point, if at least one byte was buffered, the block enters an internal write cycle. It raises `busy_o` for a parameterised number of cycles and copies into the array only the buffer entries that received data. While the cycle runs, new bytes and new transactions are refused. A transaction that ends without data commits nothing and never raises busy. A single-byte write is simply a page write of length one. A read port on the array model lets the surrounding logic inspect stored contents.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset `busy_o` and `byte_ack_o` are low and every array location reads as zero.
- R2: A pulse on `open_i` starts a transaction. The page number is taken from bits [ADDR_W-1:3] of `open_addr_i` and the starting offset from bits [2:0]. The first accepted byte is stored at exactly that address.
- R3: Each accepted byte advances the offset by one, modulo 8. The page bits stay fixed, so bytes that pass the end of the page land at the start of the same page.
- R4: When more than 8 bytes are accepted in one transaction, the later bytes replace the earlier bytes at the same offsets. The commit stores the last byte written to each offset.
- R5: The array is not written before the end-of-transaction pulse (`stop_i`) arrives. Writes happen only while `busy_o` is high.
- R6: When `stop_i` ends a transaction that holds at least one byte, `busy_o` rises after that clock edge and stays high for exactly BUSY_CYC cycles. BUSY_CYC must be at least 8.
- R7: The commit writes only the offsets that received a byte in the current transaction. All other locations in the page keep their previous contents.
- R8: When `stop_i` ends a transaction that holds no byte, nothing is written and `busy_o` stays low.
- R9: While `busy_o` is high, `byte_ack_o` stays low for any input. The bytes and `open_i` pulses presented during that time have no effect on the array or on later transactions.
- R10: `byte_ack_o` is high in a cycle exactly when `byte_vld_i` is high, a transaction is open, the commit is not running and `open_i` is low. Bytes outside a transaction are ignored.
- R11: A one-byte transaction goes through the same buffer and commit path. It changes exactly one location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| open_i | input | 1 | Transaction start pulse |
| open_addr_i | input | ADDR_W | Word address of the transaction |
| byte_vld_i | input | 1 | Data byte present |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | End-of-transaction pulse |
| byte_ack_o | output | 1 | Byte taken this cycle |
| busy_o | output | 1 | Internal write cycle in progress |
| peek_addr_i | input | ADDR_W | Array read address |
| peek_data_o | output | DATA_W | Array read data, one cycle after the address |

## Verification
The bench builds the block with ADDR_W=6, which gives eight pages, and with BUSY_CYC=11. With only eight pages, the whole 64-location array can be mirrored and checked after every commit, including the top page, where offset wrap meets the highest address. A busy window of 11 cycles is longer than the 8-cycle copy, so the exact busy length is tested separately from the copy itself. The window is also short enough that bytes and open pulses can be injected in its middle and checked for refusal.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FILL   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;
endpackage

// File: rtl/pgbuf_pagebuf.sv
module pgbuf_pagebuf #(
    parameter int OFFS_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFFS_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFFS_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int ENTRIES = 1 << OFFS_W;

    logic [DATA_W-1:0] slot_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && waddr == OFFS_W'(g)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                cell_q[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (we) begin
                cell_q[waddr] <= wdata;
            end
            rdata <= cell_q[raddr];
        end
    end
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFFS_W   = 3,
    parameter int DATA_W   = 8,
    parameter int BUSY_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic [ADDR_W-1:0] open_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    output logic              byte_ack_o,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o
);
    localparam int PAGE   = 1 << OFFS_W;
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int CNT_W  = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [PAGE_W-1:0] page;
        logic [OFFS_W-1:0] offs;
        logic [PAGE-1:0]   mask;
        logic [OFFS_W:0]   idx;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;

    logic              take;
    logic [PAGE-1:0]   mask_upd;
    logic [OFFS_W-1:0] copy_idx;
    logic [DATA_W-1:0] copy_data;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [PAGE-1:0]   mask_q;

    assign copy_idx = st_q.idx[OFFS_W-1:0];
    assign mask_q   = st_q.mask;

    always_comb begin
        st_d     = st_q;
        take     = byte_vld_i && (st_q.phase == PH_FILL) && !open_i;
        mask_upd = st_q.mask | (take ? (PAGE'(1) << st_q.offs) : '0);
        arr_we   = (st_q.phase == PH_COMMIT) && !st_q.idx[OFFS_W]
                   && st_q.mask[copy_idx];
        arr_waddr = {st_q.page, copy_idx};

        case (st_q.phase)
            PH_IDLE, PH_FILL: begin
                if (open_i) begin
                    st_d.phase = PH_FILL;
                    st_d.page  = open_addr_i[ADDR_W-1:OFFS_W];
                    st_d.offs  = open_addr_i[OFFS_W-1:0];
                    st_d.mask  = '0;
                end else if (st_q.phase == PH_FILL) begin
                    if (take) begin
                        st_d.offs = st_q.offs + OFFS_W'(1);
                        st_d.mask = mask_upd;
                    end
                    if (stop_i) begin
                        if (mask_upd != '0) begin
                            st_d.phase = PH_COMMIT;
                            st_d.idx   = '0;
                            st_d.cnt   = CNT_W'(BUSY_CYC - 1);
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
            end
            PH_COMMIT: begin
                if (!st_q.idx[OFFS_W]) begin
                    st_d.idx = st_q.idx + (OFFS_W+1)'(1);
                end
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    pgbuf_pagebuf #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_pagebuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (take),
        .waddr (st_q.offs),
        .wdata (byte_i),
        .raddr (copy_idx),
        .rdata (copy_data)
    );

    pgbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (copy_data),
        .raddr (peek_addr_i),
        .rdata (peek_data_o)
    );

    assign byte_ack_o = take;
    assign busy_o     = (st_q.phase == PH_COMMIT);
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
    parameter int OFFS_W   = 3,
    parameter int BUSY_CYC = 40
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   open_i,
    input logic                   byte_vld_i,
    input logic                   stop_i,
    input logic                   byte_ack_o,
    input logic                   busy_o,
    input logic                   arr_we,
    input logic [(1<<OFFS_W)-1:0] mask_q
);
    localparam int RUN_W = $clog2(BUSY_CYC + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !byte_ack_o);

    p_ack_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack_o |-> (byte_vld_i && !open_i));

    p_busy_follows_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && byte_ack_o) |=> busy_o);

    p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == RUN_W'(BUSY_CYC)));

    p_write_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy_o);

    p_empty_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !byte_ack_o && mask_q == '0) |=> !busy_o);
endmodule

bind pgbuf_commit pgbuf_commit_chk #(.OFFS_W(OFFS_W), .BUSY_CYC(BUSY_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (open_i),
    .byte_vld_i (byte_vld_i),
    .stop_i     (stop_i),
    .byte_ack_o (byte_ack_o),
    .busy_o     (busy_o),
    .arr_we     (arr_we),
    .mask_q     (mask_q)
);

// File: tb/pgbuf_commit_test.sv
module pgbuf_commit_test;
    localparam int ADDR_W = 6;
    localparam int OFFS_W = 3;
    localparam int DATA_W = 8;
    localparam int BUSY_CYC = 11;
    localparam int WORDS = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              open_i = 1'b0;
    logic [ADDR_W-1:0] open_addr_i = '0;
    logic              byte_vld_i = 1'b0;
    logic [DATA_W-1:0] byte_i = '0;
    logic              stop_i = 1'b0;
    logic              byte_ack_o;
    logic              busy_o;
    logic [ADDR_W-1:0] peek_addr_i = '0;
    logic [DATA_W-1:0] peek_data_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] exp_mem [WORDS];
    logic [ADDR_W-1:0] t_addr;
    logic [DATA_W-1:0] t_buf [8];
    logic [7:0]        t_mask;

    always #10 clk = ~clk;

    pgbuf_commit #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W),
                   .BUSY_CYC(BUSY_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .open_i(open_i), .open_addr_i(open_addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i),
        .byte_ack_o(byte_ack_o), .busy_o(busy_o),
        .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic open_tx(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        open_i = 1'b1; open_addr_i = a;
        @(negedge clk);
        open_i = 1'b0;
        t_addr = a; t_mask = '0;
    endtask

    task automatic send(input logic [DATA_W-1:0] d, input string req, input bit exp_ack);
        byte_vld_i = 1'b1; byte_i = d;
        #1;
        check(req, 32'(byte_ack_o), 32'(exp_ack));
        @(negedge clk);
        byte_vld_i = 1'b0;
        if (exp_ack) begin
            t_buf[t_addr[2:0]] = d;
            t_mask[t_addr[2:0]] = 1'b1;
            t_addr = {t_addr[ADDR_W-1:3], t_addr[2:0] + 3'd1};
        end
    endtask

    task automatic stop_and_commit(input string req);
        int run;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check(req, 32'(busy_o), 32'(t_mask != 0));
        run = 0;
        while (busy_o && run < 100) begin
            run++;
            @(negedge clk);
        end
        if (t_mask != 0) check("R6 busy length", 32'(run), 32'(BUSY_CYC));
        for (int k = 0; k < 8; k++) begin
            if (t_mask[k]) exp_mem[{t_addr[ADDR_W-1:3], 3'(k)}] = t_buf[k];
        end
        t_mask = '0;
    endtask

    task automatic peek_all(input string req);
        for (int a = 0; a < WORDS; a++) begin
            peek_addr_i = ADDR_W'(a);
            @(negedge clk);
            check(req, 32'(peek_data_o), 32'(exp_mem[a]));
        end
    endtask

    task automatic t_reset;
        check("R1 busy", 32'(busy_o), 0);
        byte_vld_i = 1'b1; #1;
        check("R10 ack idle", 32'(byte_ack_o), 0);
        @(negedge clk); byte_vld_i = 1'b0;
        peek_all("R1 array zero");
    endtask

    task automatic t_single;
        open_tx(6'h13);
        send(8'hA5, "R11 ack", 1'b1);
        peek_all("R5 nothing before stop");
        stop_and_commit("R11 busy");
        peek_all("R2 R7 R11 single byte");
    endtask

    task automatic t_wrap;
        open_tx(6'h15);
        for (int i = 0; i < 5; i++) send(8'h30 + 8'(i), "R3 ack", 1'b1);
        stop_and_commit("R6 busy rise");
        peek_all("R3 R7 page wrap");
    endtask

    task automatic t_overflow;
        open_tx(6'h20);
        for (int i = 0; i < 11; i++) send(8'h50 + 8'(i), "R4 ack", 1'b1);
        stop_and_commit("R6 busy rise");
        peek_all("R4 overwrite");
    endtask

    task automatic t_empty;
        open_tx(6'h2A);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check("R8 no busy", 32'(busy_o), 0);
            @(negedge clk);
        end
        peek_all("R8 nothing committed");
    endtask

    task automatic t_busy_reject;
        open_tx(6'h08);
        send(8'hC1, "R9 ack", 1'b1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R6 busy rise", 32'(busy_o), 1);
        @(negedge clk);
        byte_vld_i = 1'b1; byte_i = 8'hEE; #1;
        check("R9 no ack while busy", 32'(byte_ack_o), 0);
        @(negedge clk); byte_vld_i = 1'b0;
        open_i = 1'b1; open_addr_i = 6'h30;
        @(negedge clk); open_i = 1'b0;
        while (busy_o) @(negedge clk);
        exp_mem[6'h08] = 8'hC1;
        t_mask = '0;
        byte_vld_i = 1'b1; byte_i = 8'h77; #1;
        check("R9 R10 open ignored no ack", 32'(byte_ack_o), 0);
        @(negedge clk); byte_vld_i = 1'b0;
        peek_all("R9 rejected bytes dropped");
    endtask

    task automatic t_top_page;
        open_tx(6'h3F);
        send(8'h91, "R3 ack", 1'b1);
        send(8'h92, "R3 ack", 1'b1);
        stop_and_commit("R6 busy rise");
        peek_all("R3 top page wrap");
    endtask

    initial begin
        for (int a = 0; a < WORDS; a++) exp_mem[a] = '0;
        t_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_wrap();
        t_overflow();
        t_empty();
        t_busy_reject();
        t_top_page();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule